// File: doc/BRIEF.md
# Event Blanking Window Filter

The block picks one of several raw trip or sync events and passes it to its output, except while a blanking window is open, when the output is held inactive. The window is started by an alignment pulse taken from the time-base counter. The alignment source can be the counter-zero pulse, the period pulse, either of the two, or nothing. After the pulse the window waits a programmable number of clocks and then stays open for a programmable number of clocks. Masking a comparator event during the switch on-time in this way makes a level-type event behave like an edge event.

The offset and length are sampled together with each alignment pulse. Software may therefore rewrite the length every period to track the on-time, and the window already in progress does not change. The event path is combinational from the event inputs, so the filter adds no latency to a trip. Only the window state is registered.

Top module: `blank_window_filter`

## Requirements
- R1: Outside a blanking window, `evt_o` equals `evt_i[evt_sel_i]` in the same cycle. With no alignment pulse since reset, no window is open.
- R2: When `blank_en_i` is 0, `evt_o` equals the selected event even while a window is open.
- R3: `align_sel_i` picks the pulse that starts a window: 0 picks `zero_pulse_i`, 1 picks `prd_pulse_i`, 2 picks either of them, and 3 picks none. A pulse that is not selected has no effect on the window.
- R4: If an accepted pulse is high in cycle k, with `offset_i` = 0 and `length_i` = L > 0, the window is open in cycles k+1 through k+L.
- R5: If an accepted pulse is high in cycle k, with `offset_i` = D > 0 and `length_i` = L > 0, the window is open in cycles k+1+D through k+D+L and closed in cycles k+1 through k+D.
- R6: While a window is open and `blank_en_i` is 1, `evt_o` is 0.
- R7: A pulse that arrives with `length_i` = 0 opens no window, whatever the offset, and it cancels any window in progress.
- R8: The offset and length are sampled in the cycle of the pulse. Changing `offset_i` or `length_i` afterwards has no effect until the next accepted pulse.
- R9: A pulse accepted during the offset wait or during an open window restarts the timing from that pulse, using the newly sampled values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_EVT | Raw events |
| evt_sel_i | input | SEL_W | Index of the filtered event |
| zero_pulse_i | input | 1 | Counter-zero pulse |
| prd_pulse_i | input | 1 | Counter-period pulse |
| align_sel_i | input | 2 | Alignment source: 0 zero, 1 period, 2 either, 3 none |
| blank_en_i | input | 1 | Blanking enable; 0 bypasses the window |
| offset_i | input | CNT_W | Clocks from the pulse to the window start |
| length_i | input | CNT_W | Window length in clocks |
| evt_o | output | 1 | Filtered event |

## Verification
The bench builds the block with N_EVT = 4 and CNT_W = 6. The narrower counter makes the all-ones offset and length (63 and 63) reachable in about 130 cycles, so the end of the longest window is checked against the end of the count. Four events with a two-bit select let every source index be checked in turn. Random pulse spacing is often shorter than offset plus length, which exercises restarts during both the offset wait and the open window.

// File: rtl/blank_pkg.sv
package blank_pkg;
  typedef enum logic [1:0] {
    ALIGN_ZERO = 2'd0,
    ALIGN_PRD  = 2'd1,
    ALIGN_BOTH = 2'd2,
    ALIGN_NONE = 2'd3
  } align_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_OPEN  = 2'd2
  } win_st_e;
endpackage

// File: rtl/blank_align_sel.sv
module blank_align_sel
  import blank_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  align_e sel_i,
  input  logic   zero_i,
  input  logic   prd_i,
  output logic   align_o
);
  always_comb begin
    unique case (sel_i)
      ALIGN_ZERO: align_o = zero_i;
      ALIGN_PRD:  align_o = prd_i;
      ALIGN_BOTH: align_o = zero_i | prd_i;
      default:    align_o = 1'b0;
    endcase
  end

  AST_ALIGN_NEEDS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zero_i && !prd_i) |-> !align_o); // R3
endmodule

// File: rtl/blank_window_fsm.sv
module blank_window_fsm
  import blank_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             align_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic [CNT_W-1:0] length_i,
  output logic             win_o
);
  win_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      len_q <= '0;
    end else if (align_i) begin
      // restart from every accepted pulse, values sampled here
      len_q <= length_i;
      if (length_i == '0) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else if (offset_i == '0) begin
        st_q  <= ST_OPEN;
        cnt_q <= length_i - 1'b1;
      end else begin
        st_q  <= ST_DELAY;
        cnt_q <= offset_i - 1'b1;
      end
    end else begin
      unique case (st_q)
        ST_DELAY: begin
          if (cnt_q == '0) begin
            st_q  <= ST_OPEN;
            cnt_q <= len_q - 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_OPEN: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign win_o = (st_q == ST_OPEN);

  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_i && length_i == '0) |=> !win_o); // R7
  AST_NO_OFFSET_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_i && length_i != '0 && offset_i == '0) |=> win_o); // R4
  AST_OFFSET_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_i && offset_i != '0) |=> !win_o); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !align_i) |=> st_q == ST_IDLE); // R3
  AST_LEN_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DELAY && cnt_q == '0 && !align_i) |=> (win_o && cnt_q == $past(len_q) - 1'b1)); // R8
endmodule

// File: rtl/blank_evt_mux.sv
module blank_evt_mux #(
  parameter int N_EVT = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             blank_en_i,
  input  logic             win_i,
  output logic             evt_o
);
  logic [N_EVT-1:0] hit;
  logic             sel_evt;

  for (genvar g = 0; g < N_EVT; g++) begin : g_hit
    assign hit[g] = evt_i[g] & (sel_i == SEL_W'(g));
  end

  assign sel_evt = |hit;
  assign evt_o   = sel_evt & ~(blank_en_i & win_i);
endmodule

// File: rtl/blank_window_filter.sv
module blank_window_filter
  import blank_pkg::*;
#(
  parameter int N_EVT = 4,
  parameter int CNT_W = 8,
  parameter int SEL_W = $clog2(N_EVT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0] evt_sel_i,
  input  logic             zero_pulse_i,
  input  logic             prd_pulse_i,
  input  logic [1:0]       align_sel_i,
  input  logic             blank_en_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic [CNT_W-1:0] length_i,
  output logic             evt_o
);
  logic align;
  logic win;

  blank_align_sel u_align (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (align_e'(align_sel_i)),
    .zero_i (zero_pulse_i),
    .prd_i  (prd_pulse_i),
    .align_o(align)
  );

  blank_window_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .align_i (align),
    .offset_i(offset_i),
    .length_i(length_i),
    .win_o   (win)
  );

  blank_evt_mux #(.N_EVT(N_EVT), .SEL_W(SEL_W)) u_mux (
    .evt_i     (evt_i),
    .sel_i     (evt_sel_i),
    .blank_en_i(blank_en_i),
    .win_i     (win),
    .evt_o     (evt_o)
  );

  AST_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_en_i && win) |-> !evt_o); // R6
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_en_i |-> (evt_o == evt_i[evt_sel_i])); // R2
endmodule

// File: tb/sim_blank_window_filter.sv
module sim_blank_window_filter;
  localparam int N_EVT = 4;
  localparam int CNT_W = 6;
  localparam int SEL_W = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_EVT-1:0] evt_i = '0;
  logic [SEL_W-1:0] evt_sel_i = '0;
  logic             zero_pulse_i = 1'b0;
  logic             prd_pulse_i = 1'b0;
  logic [1:0]       align_sel_i = 2'd0;
  logic             blank_en_i = 1'b1;
  logic [CNT_W-1:0] offset_i = '0;
  logic [CNT_W-1:0] length_i = '0;
  logic             evt_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int m_p = -100000;
  int m_off = 0;
  int m_len = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  blank_window_filter #(.N_EVT(N_EVT), .CNT_W(CNT_W), .SEL_W(SEL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt_i), .evt_sel_i(evt_sel_i),
    .zero_pulse_i(zero_pulse_i), .prd_pulse_i(prd_pulse_i),
    .align_sel_i(align_sel_i), .blank_en_i(blank_en_i),
    .offset_i(offset_i), .length_i(length_i), .evt_o(evt_o)
  );

  function automatic bit accepted(logic [1:0] s, logic z, logic p);
    case (s)
      2'd0: return z;
      2'd1: return p;
      2'd2: return z | p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit in_window(int c);
    return (m_len != 0) && (c >= m_p + 1 + m_off) && (c <= m_p + m_off + m_len);
  endfunction

  // called just after a negedge with inputs already driven
  task automatic step(input string tag);
    bit act, exp;
    string t;
    #1;
    act = in_window(cyc);
    exp = evt_i[evt_sel_i] & ~(blank_en_i & act);
    t = tag;
    if (t == "") t = !act ? "R1" : (blank_en_i ? "R6" : "R2");
    n_chk++;
    if (evt_o !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: evt_o=%b expected %b", t, cyc, evt_o, exp);
    end
    if (rst_ni && accepted(align_sel_i, zero_pulse_i, prd_pulse_i)) begin
      m_p = cyc; m_off = int'(offset_i); m_len = int'(length_i);
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic pulse(input string tag, input int off, input int len);
    zero_pulse_i = 1'b1; prd_pulse_i = 1'b1;
    offset_i = CNT_W'(off); length_i = CNT_W'(len);
    step(tag);
    zero_pulse_i = 1'b0; prd_pulse_i = 1'b0;
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    @(negedge clk);
    evt_i = 4'hF;
    zero_pulse_i = 1'b1;
    run("R1", 3); // reset state: no window
    zero_pulse_i = 1'b0;
    rst_ni = 1'b1;
    run("R1", 2);

    for (int s = 0; s < N_EVT; s++) begin
      evt_sel_i = SEL_W'(s);
      evt_i = 4'b0001 << s; step("R1");
      evt_i = ~(4'b0001 << s); step("R1");
    end

    evt_i = 4'hF; evt_sel_i = 2'd2; align_sel_i = 2'd0; blank_en_i = 1'b1;
    pulse("R4", 0, 3); run("R4", 6);
    pulse("R5", 4, 5); run("R5", 12);
    pulse("R7", 2, 0); run("R7", 6);
    pulse("R7", 0, 8); run("R7", 2); pulse("R7", 1, 0); run("R7", 8);
    pulse("R8", 2, 4);
    offset_i = 6'd9; length_i = 6'd1; run("R8", 10);
    pulse("R9", 1, 6); run("R9", 3); pulse("R9", 2, 2); run("R9", 7);
    pulse("R9", 3, 3); step("R9"); pulse("R9", 0, 2); run("R9", 5);

    align_sel_i = 2'd1;
    offset_i = 6'd0; length_i = 6'd3;
    zero_pulse_i = 1'b1; step("R3"); zero_pulse_i = 1'b0; run("R3", 4);
    prd_pulse_i = 1'b1; step("R3"); prd_pulse_i = 1'b0; run("R3", 4);
    align_sel_i = 2'd3;
    pulse("R3", 0, 3); run("R3", 4);
    align_sel_i = 2'd2;
    zero_pulse_i = 1'b1; step("R3"); zero_pulse_i = 1'b0; run("R3", 4);
    prd_pulse_i = 1'b1; step("R3"); prd_pulse_i = 1'b0; run("R3", 4);
    align_sel_i = 2'd0;
    prd_pulse_i = 1'b1; step("R3"); prd_pulse_i = 1'b0; run("R3", 4);

    pulse("R2", 1, 5); blank_en_i = 1'b0; run("R2", 4); blank_en_i = 1'b1; run("R6", 4);

    pulse("R5", 63, 63); run("R5", 130);

    for (int i = 0; i < 4000; i++) begin
      evt_i = N_EVT'($urandom);
      if ($urandom_range(0, 7) == 0) evt_sel_i = SEL_W'($urandom);
      blank_en_i = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 49) == 0) align_sel_i = 2'($urandom);
      zero_pulse_i = ($urandom_range(0, 19) == 0);
      prd_pulse_i = ($urandom_range(0, 19) == 0);
      offset_i = CNT_W'($urandom_range(0, 15));
      length_i = CNT_W'($urandom_range(0, 20));
      step("");
    end
    finish_run();
  end
endmodule